// File: doc/BRIEF.md
# Segment Pair Address Scheduler

This block walks every ordered pair of segments on a coil whose point coordinates sit in three on-chip memories, one per axis, all indexed by the same point number. The coil has `TURNS` turns of `PTS` points each. Segment `s` runs from point `s` to the following point of the same turn. The last segment of a turn closes back onto that turn's first point. Each segment in turn becomes the reference, and its two endpoints are latched. Every segment of the coil is then streamed past it as a candidate, with a single read address shared by the three memories.

A candidate that is the reference itself, or that shares exactly one endpoint with it, is withheld, because its contribution is a constant added later. All other pairs leave on a valid strobe together with their four endpoint triples, at most one per clock. Consecutive candidates share a point, so each candidate costs only one read. When the walk ends, the block reports the number of segments it counted, so that the constant self and neighbour terms can be scaled by it.

Top module: `seg_pair_sched`

## Requirements
- R1: `rd_addr` carries one point index for all three memories, stays below N = PTS*TURNS while busy, and the memories answer one clock after the address is presented.
- R2: Segment s ends at point s+1, except when s is the last index of its turn (s mod PTS = PTS-1), where it ends at point s-PTS+1.
- R3: References are taken in ascending index order. For each reference, candidates are visited in ascending index order, and issued pairs keep that order.
- R4: A pair whose candidate index equals the reference index is never issued.
- R5: A pair is never issued when the candidate's end is the reference's start, or the reference's end is the candidate's start, including the wrap segments of R2. Exactly N*(N-3) pairs are issued per run for PTS >= 4.
- R6: On an issued pair, `pt0`/`pt1` are the start and end points of the reference and `pt2`/`pt3` are those of the candidate. Each point is packed as {x, y, z}, with x in the top W bits.
- R7: After `start` is accepted, `busy` stays high for exactly N*(N+3)+1 cycles. `done` is a one-cycle pulse in the first cycle in which `busy` is low, and `pair_valid` only rises while a run is in flight.
- R8: `seg_count` is cleared when a run starts and equals N when `done` pulses.
- R9: `start` while `busy` is high has no effect on the pair stream, the run length or `seg_count`.
- R10: During reset, `busy`, `done` and `pair_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| seg_count | output | IW | Segments counted in the run |
| rd_addr | output | IW | Point index to the X, Y and Z memories |
| rd_x | input | W | X memory read data |
| rd_y | input | W | Y memory read data |
| rd_z | input | W | Z memory read data |
| pair_valid | output | 1 | An issued disjoint pair is present |
| pt0 | output | 3*W | Reference start point {x,y,z} |
| pt1 | output | 3*W | Reference end point {x,y,z} |
| pt2 | output | 3*W | Candidate start point {x,y,z} |
| pt3 | output | 3*W | Candidate end point {x,y,z} |

## Verification
Two things can fall in the same cycle. One is the arrival of the first point of a new turn. The other is the emission of the previous turn's wrap segment, which needs the cached first point before that cache is overwritten. Every turn boundary, for every reference, provokes this, because point data is encoded so that each coordinate names its own index. The bench judges the result by comparing the candidate endpoints of each issued pair, and the total count of wrap-segment pairs, with values it computes arithmetically. A second collision, a `start` pulse in the middle of a run, is judged by exact run length, pair count and `seg_count`.

// File: rtl/seg_pair_sched.sv
module seg_pair_sched #(
  parameter int PTS   = 64,
  parameter int TURNS = 2,
  parameter int W     = 16,
  localparam int N    = PTS * TURNS,
  localparam int IW   = $clog2(N + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            busy,
  output logic            done,
  output logic [IW-1:0]   seg_count,
  output logic [IW-1:0]   rd_addr,
  input  logic [W-1:0]    rd_x,
  input  logic [W-1:0]    rd_y,
  input  logic [W-1:0]    rd_z,
  output logic            pair_valid,
  output logic [3*W-1:0]  pt0,
  output logic [3*W-1:0]  pt1,
  output logic [3*W-1:0]  pt2,
  output logic [3*W-1:0]  pt3
);

  localparam logic [IW-1:0] PL   = IW'(PTS);
  localparam logic [IW-1:0] LAST = IW'(N - 1);
  localparam logic [IW-1:0] ONE  = IW'(1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} st_t;
  typedef enum logic [1:0] {K_REFA, K_REFB, K_PT, K_FLUSH} kind_t;

  function automatic logic [IW-1:0] succ(input logic [IW-1:0] s);
    if ((s % PL) == PL - ONE) succ = s - PL + ONE;
    else                      succ = s + ONE;
  endfunction

  st_t           st;
  kind_t         ph, b_kind;
  logic [IW-1:0] ref_i, pt_i, b_ref, b_pt;
  logic          b_v;
  logic [3*W-1:0] ref_a, ref_b, prev_pt, first_pt;

  assign busy    = (st != S_IDLE);
  assign rd_addr = (ph == K_REFA) ? ref_i : (ph == K_REFB) ? succ(ref_i) : pt_i;

  logic [3*W-1:0] cur;
  logic           turn_start, emit, same, adj;
  logic [IW-1:0]  seg_i;
  logic [3*W-1:0] seg_b;

  assign cur        = {rd_x, rd_y, rd_z};
  assign turn_start = (b_pt % PL) == '0;
  assign emit       = b_v && (b_kind == K_FLUSH || (b_kind == K_PT && b_pt != '0));
  assign seg_i      = (b_kind == K_FLUSH) ? LAST : b_pt - ONE;
  assign seg_b      = (b_kind == K_FLUSH || turn_start) ? first_pt : cur;
  assign same       = (seg_i == b_ref);
  assign adj        = (seg_i == succ(b_ref)) || (b_ref == succ(seg_i));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ph        <= K_REFA;
      ref_i     <= '0;
      pt_i      <= '0;
      done      <= 1'b0;
      seg_count <= '0;
    end else begin
      done <= 1'b0;
      if (emit && same) seg_count <= seg_count + ONE;
      case (st)
        S_IDLE: if (start) begin
          st        <= S_RUN;
          ph        <= K_REFA;
          ref_i     <= '0;
          pt_i      <= '0;
          seg_count <= '0;
        end
        S_RUN: case (ph)
          K_REFA: ph <= K_REFB;
          K_REFB: ph <= K_PT;
          K_PT: begin
            if (pt_i == LAST) begin
              ph   <= K_FLUSH;
              pt_i <= '0;
            end else begin
              pt_i <= pt_i + ONE;
            end
          end
          default: begin
            if (ref_i == LAST) begin
              st <= S_DRAIN;
            end else begin
              ref_i <= ref_i + ONE;
              ph    <= K_REFA;
            end
          end
        endcase
        default: begin
          st   <= S_IDLE;
          done <= 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_v    <= 1'b0;
      b_kind <= K_REFA;
      b_pt   <= '0;
      b_ref  <= '0;
    end else begin
      b_v    <= (st == S_RUN);
      b_kind <= ph;
      b_pt   <= pt_i;
      b_ref  <= ref_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_a    <= '0;
      ref_b    <= '0;
      prev_pt  <= '0;
      first_pt <= '0;
    end else if (b_v) begin
      case (b_kind)
        K_REFA: ref_a <= cur;
        K_REFB: ref_b <= cur;
        K_PT: begin
          prev_pt <= cur;
          if (turn_start) first_pt <= cur;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pair_valid <= 1'b0;
      pt0 <= '0;
      pt1 <= '0;
      pt2 <= '0;
      pt3 <= '0;
    end else begin
      pair_valid <= emit && !same && !adj;
      if (emit && !same && !adj) begin
        pt0 <= ref_a;
        pt1 <= ref_b;
        pt2 <= prev_pt;
        pt3 <= seg_b;
      end
    end
  end

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n) busy |-> rd_addr < IW'(N)); // R1
  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
  AST_VALID_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n) pair_valid |-> $past(busy)); // R7
  AST_COUNT_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |-> seg_count == IW'(N)); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (busy && start) |=> (busy || done)); // R9

endmodule

// File: tb/tb_seg_pair_sched.sv
module tb_seg_pair_sched;
  localparam int P  = 4;
  localparam int T  = 3;
  localparam int W  = 8;
  localparam int N  = P * T;
  localparam int IW = $clog2(N + 1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, pair_valid;
  logic [IW-1:0] seg_count, rd_addr;
  logic [W-1:0] rx, ry, rz;
  logic [3*W-1:0] pt0, pt1, pt2, pt3;

  always #2 clk = ~clk;

  seg_pair_sched #(.PTS(P), .TURNS(T), .W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .seg_count(seg_count), .rd_addr(rd_addr), .rd_x(rx), .rd_y(ry), .rd_z(rz),
    .pair_valid(pair_valid), .pt0(pt0), .pt1(pt1), .pt2(pt2), .pt3(pt3));

  always_ff @(posedge clk) begin
    rx <= W'(rd_addr);
    ry <= W'(rd_addr) + 8'd40;
    rz <= W'(rd_addr) + 8'd80;
  end

  int n_chk = 0, n_bad = 0;
  int er, es, beats, bcyc, dcnt, wraps;
  bit mon_on = 0;

  function automatic int nx(input int i);
    return (i % P == P - 1) ? i - P + 1 : i + 1;
  endfunction
  function automatic bit distinct(input int r, input int s);
    return (s != r) && (s != nx(r)) && (r != nx(s));
  endfunction
  function automatic logic [3*W-1:0] pk(input int i);
    return {W'(i), W'(i + 40), W'(i + 80)};
  endfunction

  task automatic chk(input bit ok, input string msg);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic step();
    es++;
    if (es == N) begin es = 0; er++; end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (busy) bcyc++;
      if (done) dcnt++;
      if (pair_valid) begin
        while (er < N && !distinct(er, es)) step();
        if (er >= N) begin
          chk(1'b0, "R4 R5 extra pair issued: actual beyond end, expected none");
        end else begin
          chk({pt0, pt1, pt2, pt3} == {pk(er), pk(nx(er)), pk(es), pk(nx(es))},
              $sformatf("R1 R2 R3 R6 pair r=%0d s=%0d actual %h %h %h %h expected %h %h %h %h",
                        er, es, pt0, pt1, pt2, pt3, pk(er), pk(nx(er)), pk(es), pk(nx(es))));
          if (es % P == P - 1) wraps++;
          beats++;
          step();
        end
      end
    end
  end

  task automatic run(input bit poke);
    int guard;
    int exp_wraps;
    er = 0; es = 0; beats = 0; bcyc = 0; dcnt = 0; wraps = 0;
    mon_on = 1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (50) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    guard = 0;
    while (dcnt == 0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    chk(guard < 5000, "R7 watchdog expired: actual no done, expected done");
    repeat (4) @(negedge clk);
    mon_on = 0;
    while (er < N && !distinct(er, es)) step();
    chk(er >= N, $sformatf("R3 R4 R5 missing pairs: actual stopped at r=%0d s=%0d, expected all", er, es));
    chk(beats == N * (N - 3), $sformatf("R4 R5 R9 pair count actual %0d expected %0d", beats, N * (N - 3)));
    exp_wraps = 0;
    for (int r = 0; r < N; r++)
      for (int s = P - 1; s < N; s += P)
        if (distinct(r, s)) exp_wraps++;
    chk(wraps == exp_wraps, $sformatf("R2 wrap pairs actual %0d expected %0d", wraps, exp_wraps));
    chk(bcyc == N * (N + 3) + 1, $sformatf("R7 R9 busy cycles actual %0d expected %0d", bcyc, N * (N + 3) + 1));
    chk(dcnt == 1, $sformatf("R7 done pulses actual %0d expected 1", dcnt));
    chk(seg_count == IW'(N), $sformatf("R8 seg_count actual %0d expected %0d", seg_count, N));
    chk(!busy && !pair_valid, $sformatf("R7 idle after run actual busy=%0b valid=%0b expected 0 0", busy, pair_valid));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !pair_valid,
        $sformatf("R10 reset state actual busy=%0b done=%0b valid=%0b expected 0 0 0", busy, done, pair_valid));
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !pair_valid, "R10 idle after reset release: actual active, expected idle");
    run(1'b1);
    run(1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule